// File: doc/BRIEF.md
# CPU Bus Lock Arbiter

This block decides when the CPU hands its bus to one of two other masters: an on-chip DMA controller, and an external device that asks the CPU to hold by pulling an active-low pin. The CPU keeps an internal lock flag that software cannot read or write. Only instruction side effects change it. Read-modify-write bit instructions hold the flag for as long as they execute. A lock-load instruction sets the flag and keeps it set until an explicit unlock instruction.

While the flag is set, no new grant is issued, and a refused request stays pending. Grants are only issued in a cycle where the CPU reports its bus idle. When both requesters are pending, the external hold request wins. A granted master keeps the bus until it drops its request. The CPU bus-enable comes back one cycle after the grant or acknowledge is withdrawn. Setting the lock does not take back a grant that is already active.

Top module: `bus_lock_arbiter`

## Requirements
- R1: After reset the lock flag is clear, `cpu_bus_en` is 1, `dma_gnt` is 0 and `hold_ack_n` is 1.
- R2: A pulse on `bitop_start` sets the lock, and that lock already blocks a grant decision in the same cycle. A pulse on `bitop_done` clears a lock set this way. A request refused because of the lock is granted one cycle after the lock has cleared.
- R3: A pulse on `lockld` sets a lock that `bitop_start` and `bitop_done` cannot clear.
- R4: A pulse on `unlock` clears the lock whatever set it. A pending request is granted at the second clock edge after the unlock pulse is sampled.
- R5: No grant is issued while `cpu_busy` is 1. A request pending during that time is granted at the first clock edge at which `cpu_busy` is 0.
- R6: When `hold_req_n` is 0 and `dma_req` is 1 at a grant decision, the hold request is acknowledged. The DMA request stays pending and is granted after the hold has been released.
- R7: When a request is sampled high with the bus free, the grant appears after that one clock edge. The grant stays until the request is sampled low. It then drops at that edge, and `cpu_bus_en` returns one edge later.
- R8: A lock set while a grant is active does not withdraw that grant.
- R9: At most one of `cpu_bus_en`, `dma_gnt` and the active (0) level of `hold_ack_n` is asserted in any cycle.
- R10: The hold request and the hold acknowledge are both active low. A hold request arriving while the lock is set is only acknowledged after an unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitop_start | input | 1 | One-cycle strobe: a bit set or bit clear instruction begins |
| bitop_done | input | 1 | One-cycle strobe: that bit instruction completes |
| lockld | input | 1 | One-cycle strobe: a lock-load instruction executes |
| unlock | input | 1 | One-cycle strobe: an unlock instruction executes |
| cpu_busy | input | 1 | CPU bus access in progress; grants wait while 1 |
| dma_req | input | 1 | Bus request from the DMA controller, active high |
| hold_req_n | input | 1 | External hold request, active low |
| dma_gnt | output | 1 | Bus grant to the DMA controller |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| cpu_bus_en | output | 1 | CPU owns and may drive the bus |

## Verification
Two events can fall in the same cycle: a lock strobe and a grant decision. The bench raises `dma_req` in the very cycle that carries a `bitop_start` pulse, on an idle and unlocked bus. The lock must win, and no grant may follow. The second collision is an unlock arriving while a request waits. The bench checks that the grant lands exactly two edges after the unlock strobe, not earlier and not later.

// File: rtl/bla_pkg.sv
package bla_pkg;
  // requester indices; the lower index wins a tie
  localparam int NUM_EXT = 2;
  localparam int IDX_HOLD = 0;
  localparam int IDX_DMA  = 1;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_BITOP  = 2'd1,
    SRC_LOADLK = 2'd2
  } lock_src_e;

  typedef enum logic [1:0] {
    ST_CPU     = 2'd0,
    ST_DMA     = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RELEASE = 2'd3
  } bus_state_e;

  // keep only the lowest set bit of the pending vector
  function automatic logic [NUM_EXT-1:0] pick_winner(input logic [NUM_EXT-1:0] pend);
    return pend & (~pend + 1'b1);
  endfunction

  // next lock source from the instruction strobes
  function automatic lock_src_e next_src(input lock_src_e cur, input logic bstart,
                                         input logic bdone, input logic ld,
                                         input logic unl);
    lock_src_e n;
    n = cur;
    if (unl) n = SRC_NONE;
    else if (bdone && cur == SRC_BITOP) n = SRC_NONE;
    if (ld) n = SRC_LOADLK;
    else if (bstart && n != SRC_LOADLK) n = SRC_BITOP;
    return n;
  endfunction
endpackage

// File: rtl/bla_lock_unit.sv
module bla_lock_unit
  import bla_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bitop_start,
  input  logic bitop_done,
  input  logic lockld,
  input  logic unlock,
  output logic lock_q,
  output logic lock_eff,
  output logic lock_by_load
);
  lock_src_e src_q, src_d;

  always_comb src_d = next_src(src_q, bitop_start, bitop_done, lockld, unlock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_NONE;
    else        src_q <= src_d;
  end

  assign lock_q       = (src_q != SRC_NONE);
  assign lock_by_load = (src_q == SRC_LOADLK);
  // a strobe in this cycle already counts against a grant decision
  assign lock_eff     = lock_q | lockld | bitop_start;
endmodule

// File: rtl/bla_req_pick.sv
module bla_req_pick
  import bla_pkg::*;
#(
  parameter int N = NUM_EXT
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] win,
  output logic         any
);
  assign win = pick_winner(pend);
  assign any = |pend;
endmodule

// File: rtl/bla_grant_fsm.sv
module bla_grant_fsm
  import bla_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant_ok,
  input  logic [NUM_EXT-1:0] pend,
  input  logic [NUM_EXT-1:0] win,
  output bus_state_e         state,
  output logic               grant_fire
);
  bus_state_e state_d;

  always_comb begin
    state_d    = state;
    grant_fire = 1'b0;
    case (state)
      ST_CPU: begin
        if (grant_ok && win[IDX_HOLD]) begin
          state_d    = ST_HOLD;
          grant_fire = 1'b1;
        end else if (grant_ok && win[IDX_DMA]) begin
          state_d    = ST_DMA;
          grant_fire = 1'b1;
        end
      end
      ST_HOLD:    if (!pend[IDX_HOLD]) state_d = ST_RELEASE;
      ST_DMA:     if (!pend[IDX_DMA])  state_d = ST_RELEASE;
      default:    state_d = ST_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CPU;
    else        state <= state_d;
  end
endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter
  import bla_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bitop_start,
  input  logic bitop_done,
  input  logic lockld,
  input  logic unlock,
  input  logic cpu_busy,
  input  logic dma_req,
  input  logic hold_req_n,
  output logic dma_gnt,
  output logic hold_ack_n,
  output logic cpu_bus_en
);
  logic               lock_q, lock_eff, lock_by_load;
  logic [NUM_EXT-1:0] pend, win;
  logic               any_pend, grant_ok, grant_fire;
  bus_state_e         state;

  bla_lock_unit u_lock (
    .clk, .rst_n, .bitop_start, .bitop_done, .lockld, .unlock,
    .lock_q, .lock_eff, .lock_by_load
  );

  always_comb begin
    pend           = '0;
    pend[IDX_HOLD] = ~hold_req_n;
    pend[IDX_DMA]  = dma_req;
  end

  bla_req_pick #(.N(NUM_EXT)) u_pick (.pend(pend), .win(win), .any(any_pend));

  assign grant_ok = any_pend & ~lock_eff & ~cpu_busy;

  bla_grant_fsm u_fsm (
    .clk, .rst_n, .grant_ok, .pend, .win, .state, .grant_fire
  );

  assign dma_gnt    = (state == ST_DMA);
  assign hold_ack_n = (state != ST_HOLD);
  assign cpu_bus_en = (state == ST_CPU);
endmodule

// File: rtl/bla_checker.sv
module bla_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_busy,
  input logic dma_req,
  input logic hold_req_n,
  input logic unlock,
  input logic bitop_start,
  input logic bitop_done,
  input logic dma_gnt,
  input logic hold_ack_n,
  input logic cpu_bus_en,
  input logic lock_q,
  input logic lock_eff,
  input logic lock_by_load
);
  p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_bus_en, dma_gnt, !hold_ack_n}));

  p_lock_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_bus_en && lock_eff) |=> cpu_bus_en);

  p_load_lock_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_by_load && !unlock) |=> lock_q);

  p_unlock_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !bitop_start) |=> !lock_q);

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_bus_en && cpu_busy) |=> cpu_bus_en);

  p_hold_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_bus_en && !hold_req_n && dma_req) |=> !dma_gnt);

  p_drop_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_gnt) |-> !cpu_bus_en);

  p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_gnt) |=> cpu_bus_en);

  p_keep_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && dma_req) |=> dma_gnt);

  p_keep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack_n && !hold_req_n) |=> !hold_ack_n);
endmodule

bind bus_lock_arbiter bla_checker u_chk (.*);

// File: tb/sim_bus_lock_arbiter.sv
module sim_bus_lock_arbiter;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitop_start = 0, bitop_done = 0, lockld = 0, unlock = 0;
  logic cpu_busy = 0, dma_req = 0, hold_req_n = 1;
  logic dma_gnt, hold_ack_n, cpu_bus_en;
  int   n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_lock_arbiter u0 (.*);

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  // R9: check that at most one owner is asserted
  task automatic chk_owner(input string what);
    chk(($countones({cpu_bus_en, dma_gnt, !hold_ack_n}) <= 1), 1'b1, what);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    tick();
    s = 1'b0;
  endtask

  task automatic free_bus();
    dma_req = 0;
    hold_req_n = 1;
    tick(2);
    chk(cpu_bus_en, 1'b1, "bus back to cpu");
  endtask

  task automatic t_reset();
    chk(cpu_bus_en, 1'b1, "R1 cpu_bus_en after reset");
    chk(dma_gnt, 1'b0, "R1 dma_gnt after reset");
    chk(hold_ack_n, 1'b1, "R1 hold_ack_n after reset");
  endtask

  task automatic t_basic_dma();
    dma_req = 1;
    tick();
    chk(dma_gnt, 1'b1, "R7 grant one edge after request");
    chk(cpu_bus_en, 1'b0, "R7 cpu off during grant");
    chk_owner("R9 during dma grant");
    tick(3);
    chk(dma_gnt, 1'b1, "R7 grant held while requested");
    dma_req = 0;
    tick();
    chk(dma_gnt, 1'b0, "R7 grant drops on request drop");
    chk(cpu_bus_en, 1'b0, "R7 gap cycle");
    chk_owner("R9 in gap");
    tick();
    chk(cpu_bus_en, 1'b1, "R7 cpu returns one edge later");
  endtask

  task automatic t_hold_priority();
    dma_req = 1;
    hold_req_n = 0;
    tick();
    chk(hold_ack_n, 1'b0, "R6 hold wins tie");
    chk(dma_gnt, 1'b0, "R6 dma loses tie");
    chk_owner("R9 during hold");
    hold_req_n = 1;
    tick();
    chk(hold_ack_n, 1'b1, "R10 ack released");
    tick();
    chk(cpu_bus_en, 1'b1, "R7 cpu back after hold");
    tick();
    chk(dma_gnt, 1'b1, "R6 dma stayed pending");
    free_bus();
  endtask

  task automatic t_bitop_lock();
    dma_req = 1;
    bitop_start = 1;
    tick();
    bitop_start = 0;
    chk(dma_gnt, 1'b0, "R2 same-cycle lock blocks grant");
    tick(3);
    chk(dma_gnt, 1'b0, "R2 lock holds off dma");
    pulse(bitop_done);
    chk(dma_gnt, 1'b0, "R2 not yet granted at done edge");
    tick();
    chk(dma_gnt, 1'b1, "R2 granted after lock clears");
    free_bus();
  endtask

  task automatic t_lockld();
    pulse(lockld);
    dma_req = 1;
    pulse(bitop_start);
    pulse(bitop_done);
    chk(dma_gnt, 1'b0, "R3 bitop done keeps load lock");
    tick(3);
    chk(dma_gnt, 1'b0, "R3 load lock still blocks");
    pulse(unlock);
    chk(dma_gnt, 1'b0, "R4 no grant at unlock edge");
    tick();
    chk(dma_gnt, 1'b1, "R4 grant second edge after unlock");
    free_bus();
  endtask

  task automatic t_busy();
    cpu_busy = 1;
    dma_req = 1;
    tick(3);
    chk(dma_gnt, 1'b0, "R5 no grant while busy");
    chk(cpu_bus_en, 1'b1, "R5 cpu keeps bus while busy");
    cpu_busy = 0;
    tick();
    chk(dma_gnt, 1'b1, "R5 grant on first idle edge");
    free_bus();
  endtask

  task automatic t_no_revoke();
    dma_req = 1;
    tick();
    chk(dma_gnt, 1'b1, "R8 grant before lock");
    pulse(lockld);
    chk(dma_gnt, 1'b1, "R8 lock does not revoke");
    tick(2);
    chk(dma_gnt, 1'b1, "R8 grant still held");
    free_bus();
    hold_req_n = 0;
    tick(2);
    chk(hold_ack_n, 1'b1, "R10 hold refused under lock");
    pulse(unlock);
    tick();
    chk(hold_ack_n, 1'b0, "R10 hold acked after unlock");
    free_bus();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_basic_dma();
    t_hold_priority();
    t_bitop_lock();
    t_lockld();
    t_busy();
    t_no_revoke();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule